// File: doc/BRIEF.md
# Packet Page Allocator

This block keeps track of a small pool of fixed-size packet buffer pages inside a network controller. A host register interface issues 3-bit memory-management commands that allocate a page for transmission, free pages, and manage three short queues of page numbers. The receive queue holds pages with frames that have arrived. The transmit queue holds pages waiting to be sent. The completion queue holds pages that have been sent and not yet taken back by the host. The block only moves page numbers. Packet storage, framing and CRC are handled elsewhere.

A receive-side port asks for a page for each incoming frame. The block grants the lowest free page and appends that page to the receive queue. When the host frees a page while an earlier transmit allocation is still marked as failed, the block repeats that allocation at once. The block gives the interrupt unit an allocation-done flag and a receive-pending level. It also presents the heads of the receive and completion queues as 8-bit codes in which bit 7 means "empty".

Each cycle carries at most one operation. A host command comes first. Next is the sending of the transmit queue head, when transmission is enabled. A receive request comes last. The completion-queue acknowledge can occur in any cycle.

Top module: `packet_page_alloc`

## Requirements
- R1: After reset no page is in use (usedCount 0), allocResult is 0x00, allocDone and rxPending are low, both head codes read 0x80 (empty), and rxReady is high.
- R2: Command code 1 (allocate for transmit) grants the lowest-numbered free page. allocResult shows that page number in the following cycle, allocDone is set, and usedCount rises by one.
- R3: When all pages are in use, command 1 makes allocResult 0x80 and clears allocDone. No page changes state.
- R4: When any page is freed while allocResult reads 0x80, the allocation is repeated in that same cycle. allocResult then shows the lowest free page, and allocDone is set.
- R5: A receive request taken while rxEnable is high claims the lowest free page and appends it to the receive queue. In the next cycle rxGrantValid pulses and rxGrantPage shows that page.
- R6: rxReady is low in any cycle where a command is presented or the transmit queue head is being sent. With rxEnable high, it is also low when every page is in use or the receive queue holds QUEUE_DEPTH entries.
- R7: With rxEnable low, a receive request is accepted and discarded. It gives no grant, and usedCount does not change.
- R8: Command code 3 removes the receive queue head and keeps its page. Command code 4 removes the head and frees its page. On an empty receive queue, both commands have no effect.
- R9: Command code 5 frees the page given on pktNum.
- R10: Command code 6 appends pktNum to the transmit queue. A push to a full queue is ignored. While txEnable is high, one entry leaves the queue per cycle, in order, and is reported by a one-cycle txSendValid pulse with txSendPage. With autoRelease high the sent page is freed. Otherwise the sent page is appended to the completion queue.
- R11: The completion queue holds at most QUEUE_DEPTH entries, and further pushes are dropped. doneAck removes its head, and the head code reads 0x80 when the queue is empty.
- R12: Command code 7 empties the transmit and completion queues and leaves page ownership unchanged.
- R13: Command code 2 frees every page, empties all three queues, sets allocResult to 0x00 and clears allocDone.
- R14: Command code 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A host command is presented this cycle |
| cmdCode | input | 3 | Command code (0..7, see requirements) |
| pktNum | input | log2(NUM_PAGES) | Page operand for free and transmit-push commands |
| txEnable | input | 1 | Allows the transmit queue to be sent |
| autoRelease | input | 1 | Free sent pages instead of queuing them for completion |
| rxEnable | input | 1 | Receive enable; when low, requests are discarded |
| rxReq | input | 1 | Receive side asks for a page |
| doneAck | input | 1 | Remove the completion queue head |
| rxReady | output | 1 | A receive request would be taken this cycle |
| rxGrantValid | output | 1 | One-cycle pulse: a receive page was granted |
| rxGrantPage | output | log2(NUM_PAGES) | Granted receive page |
| txSendValid | output | 1 | One-cycle pulse: a transmit page was sent |
| txSendPage | output | log2(NUM_PAGES) | Page that was sent |
| allocResult | output | 8 | Transmit allocation result, 0x80 on failure |
| allocDone | output | 1 | Transmit allocation succeeded |
| rxPending | output | 1 | Receive queue is not empty |
| rxHeadCode | output | 8 | Receive queue head, 0x80 when empty |
| doneHeadCode | output | 8 | Completion queue head, 0x80 when empty |
| usedCount | output | log2(NUM_PAGES+1) | Number of pages in use |

## Verification
An ownership mask that has lost or gained a bit appears in the next cycle as a wrong usedCount. A few operations later it also shows up as a page number granted twice, or as a failed allocation while pages are free. Queue ordering or depth faults appear as wrong head codes or txSendPage values in the cycle after the offending push or pop. Capacity limits only show after enough acknowledges have drained the completion queue to expose the dropped entry. An automatic retry that did not happen leaves allocResult at 0x80 in the cycle right after the page is freed, which makes that fault visible immediately.

// File: rtl/page_alloc_pkg.sv
package page_alloc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP       = 3'd0,
    CMD_ALLOC_TX  = 3'd1,
    CMD_MMU_RESET = 3'd2,
    CMD_RX_DROP   = 3'd3,
    CMD_RX_FREE   = 3'd4,
    CMD_FREE_PAGE = 3'd5,
    CMD_TX_PUSH   = 3'd6,
    CMD_TX_FLUSH  = 3'd7
  } mmuCmd_e;

  localparam int RES_W = 8;
  localparam logic [RES_W-1:0] FAIL_CODE = 8'h80;

  // One-cycle operation strobes from control to datapath
  typedef struct packed {
    logic allocTx;
    logic mmuReset;
    logic rxPop;
    logic rxPopFree;
    logic freePage;
    logic txPush;
    logic txFlush;
    logic txDrain;
    logic rxTake;
    logic doneAck;
  } strobes_t;

endpackage

// File: rtl/page_queue.sv
module page_queue #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           clear,
  input  logic                           push,
  input  logic                           pop,
  input  logic [WIDTH-1:0]               pushData,
  output logic [WIDTH-1:0]               head,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int CNT_W = $clog2(DEPTH+1);

  logic [WIDTH-1:0] slots [DEPTH];
  logic             doPop, doPush;
  logic [CNT_W-1:0] wrIdx;

  // a pop always frees a slot, so a full queue may push alongside a pop
  assign doPop  = pop && (count != '0);
  assign doPush = push && ((count != CNT_W'(DEPTH)) || doPop);
  assign wrIdx  = doPop ? count - CNT_W'(1) : count;
  assign head   = slots[0];

  always_ff @(posedge clk) begin
    if (!rstN || clear) begin
      count <= '0;
    end else begin
      count <= count + CNT_W'(doPush) - CNT_W'(doPop);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (doPush && wrIdx == CNT_W'(i)) begin
        slots[i] <= pushData;
      end else if (doPop && i < DEPTH-1) begin
        slots[i] <= slots[(i+1) % DEPTH];
      end
    end
  end

endmodule

// File: rtl/page_alloc_ctrl.sv
module page_alloc_ctrl
  import page_alloc_pkg::*;
(
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       doneAck,
  input  logic       txEnable,
  input  logic       rxEnable,
  input  logic       rxReq,
  input  logic       poolFull,
  input  logic       rxQFull,
  input  logic       txQEmpty,
  output strobes_t   st,
  output logic       rxReady
);
  logic drainNow, rxRoom;

  // priority: host command, then transmit send, then receive
  assign drainNow = txEnable && !txQEmpty && !cmdValid;
  assign rxRoom   = !rxEnable || (!poolFull && !rxQFull);
  assign rxReady  = !cmdValid && !drainNow && rxRoom;

  always_comb begin
    st = '0;
    if (cmdValid) begin
      case (mmuCmd_e'(cmdCode))
        CMD_ALLOC_TX:  st.allocTx   = 1'b1;
        CMD_MMU_RESET: st.mmuReset  = 1'b1;
        CMD_RX_DROP:   st.rxPop     = 1'b1;
        CMD_RX_FREE:   st.rxPopFree = 1'b1;
        CMD_FREE_PAGE: st.freePage  = 1'b1;
        CMD_TX_PUSH:   st.txPush    = 1'b1;
        CMD_TX_FLUSH:  st.txFlush   = 1'b1;
        default:       ;
      endcase
    end
    st.txDrain = drainNow;
    st.rxTake  = rxReq && rxReady && rxEnable;
    st.doneAck = doneAck;
  end

endmodule

// File: rtl/page_alloc_dp.sv
module page_alloc_dp
  import page_alloc_pkg::*;
#(
  parameter int NUM_PAGES   = 4,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobes_t                         st,
  input  logic [$clog2(NUM_PAGES)-1:0]     pktNum,
  input  logic                             autoRelease,
  output logic                             poolFull,
  output logic                             rxQFull,
  output logic                             txQEmpty,
  output logic                             rxGrantValid,
  output logic [$clog2(NUM_PAGES)-1:0]     rxGrantPage,
  output logic                             txSendValid,
  output logic [$clog2(NUM_PAGES)-1:0]     txSendPage,
  output logic [RES_W-1:0]                 allocResult,
  output logic                             allocDone,
  output logic                             rxPending,
  output logic [RES_W-1:0]                 rxHeadCode,
  output logic [RES_W-1:0]                 doneHeadCode,
  output logic [$clog2(NUM_PAGES+1)-1:0]   usedCount
);
  localparam int PAGE_W = $clog2(NUM_PAGES);
  localparam int CNT_W  = $clog2(NUM_PAGES+1);
  localparam int QCNT_W = $clog2(QUEUE_DEPTH+1);

  logic [NUM_PAGES-1:0] usedMask, maskNext, maskAfterRel;
  logic [RES_W-1:0]     resNext;
  logic                 doneNext;
  logic                 relEn;
  logic [PAGE_W-1:0]    relPage;
  logic [PAGE_W:0]      freeNow, freeAfter;
  logic [PAGE_W-1:0]    rxHead, txHead, doneHead;
  logic [QCNT_W-1:0]    rxCnt, txCnt, doneCnt;

  // bit PAGE_W set means no free page
  function automatic logic [PAGE_W:0] firstFree(input logic [NUM_PAGES-1:0] m);
    firstFree = {1'b1, {PAGE_W{1'b0}}};
    for (int i = NUM_PAGES-1; i >= 0; i--) begin
      if (!m[i]) firstFree = {1'b0, PAGE_W'(i)};
    end
  endfunction

  // at most one free source per cycle, thanks to control priority
  always_comb begin
    relEn   = 1'b0;
    relPage = '0;
    if (st.rxPopFree && rxCnt != '0) begin
      relEn   = 1'b1;
      relPage = rxHead;
    end else if (st.freePage) begin
      relEn   = 1'b1;
      relPage = pktNum;
    end else if (st.txDrain && autoRelease) begin
      relEn   = 1'b1;
      relPage = txHead;
    end
  end

  assign maskAfterRel = usedMask & ~(NUM_PAGES'(relEn) << relPage);
  assign freeNow      = firstFree(usedMask);
  assign freeAfter    = firstFree(maskAfterRel);

  always_comb begin
    maskNext = usedMask;
    resNext  = allocResult;
    doneNext = allocDone;
    if (st.mmuReset) begin
      maskNext = '0;
      resNext  = '0;
      doneNext = 1'b0;
    end else if (st.allocTx) begin
      if (!freeNow[PAGE_W]) begin
        maskNext = usedMask | (NUM_PAGES'(1) << freeNow[PAGE_W-1:0]);
        resNext  = RES_W'(freeNow[PAGE_W-1:0]);
        doneNext = 1'b1;
      end else begin
        resNext  = FAIL_CODE;
        doneNext = 1'b0;
      end
    end else if (st.rxTake) begin
      if (!freeNow[PAGE_W]) begin
        maskNext = usedMask | (NUM_PAGES'(1) << freeNow[PAGE_W-1:0]);
      end
    end else if (relEn) begin
      maskNext = maskAfterRel;
      // a failed transmit allocation is retried on every free
      if (allocResult == FAIL_CODE && !freeAfter[PAGE_W]) begin
        maskNext = maskAfterRel | (NUM_PAGES'(1) << freeAfter[PAGE_W-1:0]);
        resNext  = RES_W'(freeAfter[PAGE_W-1:0]);
        doneNext = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      usedMask     <= '0;
      allocResult  <= '0;
      allocDone    <= 1'b0;
      rxGrantValid <= 1'b0;
      rxGrantPage  <= '0;
      txSendValid  <= 1'b0;
      txSendPage   <= '0;
    end else begin
      usedMask     <= maskNext;
      allocResult  <= resNext;
      allocDone    <= doneNext;
      rxGrantValid <= st.rxTake;
      rxGrantPage  <= freeNow[PAGE_W-1:0];
      txSendValid  <= st.txDrain;
      txSendPage   <= txHead;
    end
  end

  page_queue #(.DEPTH(QUEUE_DEPTH), .WIDTH(PAGE_W)) rxQueue (
    .clk(clk), .rstN(rstN), .clear(st.mmuReset),
    .push(st.rxTake), .pop(st.rxPop || st.rxPopFree),
    .pushData(freeNow[PAGE_W-1:0]), .head(rxHead), .count(rxCnt)
  );

  page_queue #(.DEPTH(QUEUE_DEPTH), .WIDTH(PAGE_W)) txQueue (
    .clk(clk), .rstN(rstN), .clear(st.mmuReset || st.txFlush),
    .push(st.txPush), .pop(st.txDrain),
    .pushData(pktNum), .head(txHead), .count(txCnt)
  );

  page_queue #(.DEPTH(QUEUE_DEPTH), .WIDTH(PAGE_W)) doneQueue (
    .clk(clk), .rstN(rstN), .clear(st.mmuReset || st.txFlush),
    .push(st.txDrain && !autoRelease), .pop(st.doneAck),
    .pushData(txHead), .head(doneHead), .count(doneCnt)
  );

  always_comb begin
    usedCount = '0;
    for (int i = 0; i < NUM_PAGES; i++) usedCount += CNT_W'(usedMask[i]);
  end

  assign poolFull     = &usedMask;
  assign rxQFull      = (rxCnt == QCNT_W'(QUEUE_DEPTH));
  assign txQEmpty     = (txCnt == '0);
  assign rxPending    = (rxCnt != '0);
  assign rxHeadCode   = (rxCnt == '0)   ? FAIL_CODE : RES_W'(rxHead);
  assign doneHeadCode = (doneCnt == '0) ? FAIL_CODE : RES_W'(doneHead);

endmodule

// File: rtl/packet_page_alloc.sv
module packet_page_alloc
  import page_alloc_pkg::*;
#(
  parameter int NUM_PAGES   = 4,
  parameter int QUEUE_DEPTH = 4
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           cmdValid,
  input  logic [2:0]                     cmdCode,
  input  logic [$clog2(NUM_PAGES)-1:0]   pktNum,
  input  logic                           txEnable,
  input  logic                           autoRelease,
  input  logic                           rxEnable,
  input  logic                           rxReq,
  input  logic                           doneAck,
  output logic                           rxReady,
  output logic                           rxGrantValid,
  output logic [$clog2(NUM_PAGES)-1:0]   rxGrantPage,
  output logic                           txSendValid,
  output logic [$clog2(NUM_PAGES)-1:0]   txSendPage,
  output logic [7:0]                     allocResult,
  output logic                           allocDone,
  output logic                           rxPending,
  output logic [7:0]                     rxHeadCode,
  output logic [7:0]                     doneHeadCode,
  output logic [$clog2(NUM_PAGES+1)-1:0] usedCount
);
  strobes_t st;
  logic     poolFull, rxQFull, txQEmpty;

  page_alloc_ctrl ctrl (
    .cmdValid(cmdValid), .cmdCode(cmdCode), .doneAck(doneAck),
    .txEnable(txEnable), .rxEnable(rxEnable), .rxReq(rxReq),
    .poolFull(poolFull), .rxQFull(rxQFull), .txQEmpty(txQEmpty),
    .st(st), .rxReady(rxReady)
  );

  page_alloc_dp #(.NUM_PAGES(NUM_PAGES), .QUEUE_DEPTH(QUEUE_DEPTH)) dp (
    .clk(clk), .rstN(rstN), .st(st), .pktNum(pktNum),
    .autoRelease(autoRelease), .poolFull(poolFull), .rxQFull(rxQFull),
    .txQEmpty(txQEmpty), .rxGrantValid(rxGrantValid),
    .rxGrantPage(rxGrantPage), .txSendValid(txSendValid),
    .txSendPage(txSendPage), .allocResult(allocResult),
    .allocDone(allocDone), .rxPending(rxPending), .rxHeadCode(rxHeadCode),
    .doneHeadCode(doneHeadCode), .usedCount(usedCount)
  );

endmodule

// File: rtl/packet_page_alloc_chk.sv
module packet_page_alloc_chk #(
  parameter int NUM_PAGES = 4
) (
  input logic                           clk,
  input logic                           rstN,
  input logic                           cmdValid,
  input logic [2:0]                     cmdCode,
  input logic                           rxEnable,
  input logic                           rxReq,
  input logic                           rxReady,
  input logic                           rxGrantValid,
  input logic                           txSendValid,
  input logic [7:0]                     allocResult,
  input logic                           allocDone,
  input logic                           rxPending,
  input logic [7:0]                     rxHeadCode,
  input logic [7:0]                     doneHeadCode,
  input logic [$clog2(NUM_PAGES+1)-1:0] usedCount
);

  // R2 R3
  alloc_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == 3'd1 |=>
      (allocDone && allocResult < NUM_PAGES) || (!allocDone && allocResult == 8'h80));

  // R13
  mmu_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == 3'd2 |=>
      usedCount == '0 && rxHeadCode == 8'h80 && doneHeadCode == 8'h80 &&
      allocResult == 8'h00 && !allocDone);

  // R6
  rx_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !rxReady);

  // R6
  rx_room_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxReady && rxEnable |-> usedCount < NUM_PAGES);

  // R5
  rx_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxReq && rxReady && rxEnable |=> rxGrantValid);

  // R7
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxReq && rxReady && !rxEnable |=> !rxGrantValid && $stable(usedCount));

  // R12
  tx_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdCode == 3'd7 |=> doneHeadCode == 8'h80 && !txSendValid);

  // R8
  rx_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxPending == (rxHeadCode != 8'h80));

endmodule

bind packet_page_alloc packet_page_alloc_chk #(.NUM_PAGES(NUM_PAGES)) chkInst (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
  .rxEnable(rxEnable), .rxReq(rxReq), .rxReady(rxReady),
  .rxGrantValid(rxGrantValid), .txSendValid(txSendValid),
  .allocResult(allocResult), .allocDone(allocDone), .rxPending(rxPending),
  .rxHeadCode(rxHeadCode), .doneHeadCode(doneHeadCode), .usedCount(usedCount)
);

// File: tb/packet_page_alloc_tb_top.sv
module packet_page_alloc_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdCode = '0;
  logic [1:0] pktNum = '0;
  logic       txEnable = 1'b0, autoRelease = 1'b0, rxEnable = 1'b0;
  logic       rxReq = 1'b0, doneAck = 1'b0;
  logic       rxReady, rxGrantValid, txSendValid, allocDone, rxPending;
  logic [1:0] rxGrantPage, txSendPage;
  logic [7:0] allocResult, rxHeadCode, doneHeadCode;
  logic [2:0] usedCount;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  packet_page_alloc dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .pktNum(pktNum), .txEnable(txEnable), .autoRelease(autoRelease),
    .rxEnable(rxEnable), .rxReq(rxReq), .doneAck(doneAck),
    .rxReady(rxReady), .rxGrantValid(rxGrantValid), .rxGrantPage(rxGrantPage),
    .txSendValid(txSendValid), .txSendPage(txSendPage),
    .allocResult(allocResult), .allocDone(allocDone), .rxPending(rxPending),
    .rxHeadCode(rxHeadCode), .doneHeadCode(doneHeadCode), .usedCount(usedCount)
  );

  // {cmd[16:14], pkt[13:12], result[11:4], used[3:1], done[0]}
  localparam logic [16:0] VECS [12] = '{
    {3'd1, 2'd0, 8'h00, 3'd1, 1'b1},
    {3'd1, 2'd0, 8'h01, 3'd2, 1'b1},
    {3'd1, 2'd0, 8'h02, 3'd3, 1'b1},
    {3'd1, 2'd0, 8'h03, 3'd4, 1'b1},
    {3'd1, 2'd0, 8'h80, 3'd4, 1'b0},
    {3'd5, 2'd1, 8'h01, 3'd4, 1'b1},
    {3'd5, 2'd2, 8'h01, 3'd3, 1'b1},
    {3'd1, 2'd0, 8'h02, 3'd4, 1'b1},
    {3'd0, 2'd0, 8'h02, 3'd4, 1'b1},
    {3'd5, 2'd0, 8'h02, 3'd3, 1'b1},
    {3'd2, 2'd0, 8'h00, 3'd0, 1'b0},
    {3'd1, 2'd0, 8'h00, 3'd1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doCmd(input logic [2:0] c, input logic [1:0] p);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = c; pktNum = p;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic rxOne(input logic expGrant, input logic [1:0] expPage, input string req);
    @(negedge clk);
    rxReq = 1'b1;
    @(negedge clk);
    rxReq = 1'b0;
    chk(req, rxGrantValid, expGrant);
    if (expGrant) chk(req, rxGrantPage, expPage);
  endtask

  task automatic ack();
    @(negedge clk);
    doneAck = 1'b1;
    @(negedge clk);
    doneAck = 1'b0;
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 used", usedCount, 0);
    chk("R1 result", allocResult, 8'h00);
    chk("R1 done", allocDone, 0);
    chk("R1 pending", rxPending, 0);
    chk("R1 rxHead", rxHeadCode, 8'h80);
    chk("R1 doneHead", doneHeadCode, 8'h80);
    chk("R1 rxReady", rxReady, 1);

    // command table walk
    for (int i = 0; i < 12; i++) begin
      string tag;
      case (VECS[i][16:14])
        3'd0: tag = "R14";
        3'd1: tag = "R2/R3";
        3'd2: tag = "R13";
        default: tag = "R4/R9";
      endcase
      doCmd(VECS[i][16:14], VECS[i][13:12]);
      chk(tag, allocResult, VECS[i][11:4]);
      chk(tag, usedCount, VECS[i][3:1]);
      chk(tag, allocDone, VECS[i][0]);
    end

    // R6 busy while a command is presented
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 3'd0;
    #1 chk("R6 busy", rxReady, 0);
    @(negedge clk);
    cmdValid = 1'b0;

    // R5 receive fills the pool
    doCmd(3'd2, 2'd0);
    rxEnable = 1'b1;
    for (int i = 0; i < 4; i++) rxOne(1'b1, 2'(i), "R5");
    chk("R5 used", usedCount, 4);
    chk("R5 head", rxHeadCode, 8'h00);
    chk("R5 pending", rxPending, 1);
    chk("R6 full", rxReady, 0);

    // R8 pop without and with free
    doCmd(3'd3, 2'd0);
    chk("R8 pop head", rxHeadCode, 8'h01);
    chk("R8 pop used", usedCount, 4);
    doCmd(3'd4, 2'd0);
    chk("R8 popfree head", rxHeadCode, 8'h02);
    chk("R8 popfree used", usedCount, 3);
    rxOne(1'b1, 2'd1, "R8 freed page reused");
    chk("R8 head kept", rxHeadCode, 8'h02);

    // R7 disabled receive discards
    rxEnable = 1'b0;
    #1 chk("R7 ready", rxReady, 1);
    rxOne(1'b0, 2'd0, "R7 no grant");
    chk("R7 used", usedCount, 4);

    // R8 pop on empty queue
    doCmd(3'd2, 2'd0);
    doCmd(3'd4, 2'd0);
    chk("R8 empty used", usedCount, 0);
    chk("R8 empty head", rxHeadCode, 8'h80);

    // R10 send to completion queue
    doCmd(3'd1, 2'd0);
    doCmd(3'd1, 2'd0);
    doCmd(3'd6, 2'd0);
    doCmd(3'd6, 2'd1);
    chk("R10 held", txSendValid, 0);
    chk("R10 held done", doneHeadCode, 8'h80);
    @(negedge clk); txEnable = 1'b1;
    @(negedge clk);
    chk("R10 send0 v", txSendValid, 1);
    chk("R10 send0 p", txSendPage, 0);
    chk("R10 done0", doneHeadCode, 8'h00);
    @(negedge clk);
    chk("R10 send1 v", txSendValid, 1);
    chk("R10 send1 p", txSendPage, 1);
    @(negedge clk);
    chk("R10 idle", txSendValid, 0);
    chk("R10 used", usedCount, 2);
    ack();
    chk("R11 ack1", doneHeadCode, 8'h01);
    ack();
    chk("R11 ack2", doneHeadCode, 8'h80);

    // R4 retry triggered by an auto-released send
    autoRelease = 1'b1;
    doCmd(3'd1, 2'd0);
    doCmd(3'd1, 2'd0);
    doCmd(3'd1, 2'd0);
    chk("R3 fail", allocResult, 8'h80);
    doCmd(3'd6, 2'd2);
    @(negedge clk);
    chk("R10 auto send", txSendValid, 1);
    chk("R4 retry result", allocResult, 8'h02);
    chk("R4 retry done", allocDone, 1);
    chk("R4 retry used", usedCount, 4);
    chk("R10 auto no done", doneHeadCode, 8'h80);

    // R12 flush
    autoRelease = 1'b0;
    doCmd(3'd6, 2'd3);
    @(negedge clk);
    chk("R12 pre", doneHeadCode, 8'h03);
    txEnable = 1'b0;
    doCmd(3'd6, 2'd0);
    doCmd(3'd7, 2'd0);
    chk("R12 done cleared", doneHeadCode, 8'h80);
    txEnable = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R12 tx cleared", txSendValid, 0);
    chk("R12 used", usedCount, 4);

    // R11 completion cap: five sends, four kept
    for (int i = 0; i < 5; i++) doCmd(3'd6, 2'(i % 4));
    @(negedge clk);
    chk("R11 head0", doneHeadCode, 8'h00);
    ack(); chk("R11 head1", doneHeadCode, 8'h01);
    ack(); chk("R11 head2", doneHeadCode, 8'h02);
    ack(); chk("R11 head3", doneHeadCode, 8'h03);
    ack(); chk("R11 capped", doneHeadCode, 8'h80);

    finishRun();
  end

endmodule